// File: doc/BRIEF.md
# Time-Sorted Hit Stream Merger

This block combines the record streams of several self-triggered front-end chips into one output stream ordered by time. Each input carries two kinds of record: epoch markers, which open a new coarse time interval, and hits, which carry a fine offset inside the current interval together with a channel number. Each input is already in time order on its own. The merger looks at the head record of every input, takes the earliest one, and passes it on. It rebuilds the epoch marker sequence so that every epoch appears once on the output, however many inputs announced it.

A hit's full time is the pair (epoch of the last marker seen on its input, offset). An input that presents no record in a cycle counts as drained for that cycle's decision, so upstream FIFOs are expected to present records without gaps while a stream is in flight. All inputs and the output use valid/ready handshakes. A hit leaves with a global channel number made from its input index and its local channel, so hits from different chips stay distinct.

Top module: `tsm_merge`

## Requirements
- R1: While reset is held, and for the cycles until its synchronised release, out_valid is 0 and every in_ready bit is 0, even with records offered.
- R2: Output hits appear in non-decreasing order of (epoch, offset), where a hit's epoch is that of the last marker taken from its own input (0 before any marker).
- R3: Each epoch appears on the output as exactly one marker (out_mark = 1, epoch in out_field bits [EPOCH_W-1:0]), markers appear in strictly increasing epoch order, and markers for the same epoch on several inputs collapse into one.
- R4: The marker of epoch E is sent before the first hit of E, including hits that arrive before any marker on their input (they belong to epoch 0).
- R5: An epoch announced by markers but carrying no hits on any input still produces its single marker.
- R6: Hits with equal (epoch, offset) on several inputs are all sent; the one on the lowest-numbered input goes first.
- R7: A hit leaves with out_mark = 0, out_field = its offset and out_chan = {input index, local channel}; a marker leaves with out_chan = 0.
- R8: A marker for a later epoch at the head of one input is held back while another presenting input still has earlier records.
- R9: While out_valid = 1 and out_ready = 0 the output record stays unchanged, and no record is lost or repeated under back-pressure.
- R10: At most one in_ready bit is 1 in any cycle, and only on an input whose in_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | NUM_IN | Per-input record present |
| in_ready | output | NUM_IN | Per-input record taken this cycle |
| in_mark | input | NUM_IN | Per-input record kind: 1 marker, 0 hit |
| in_field | input | NUM_IN*FIELD_W | Per-input epoch (marker) or offset (hit) |
| in_chan | input | NUM_IN*CHAN_W | Per-input local channel of a hit |
| out_valid | output | 1 | Output record present |
| out_ready | input | 1 | Downstream accepts the output record |
| out_mark | output | 1 | Output record kind: 1 marker, 0 hit |
| out_field | output | FIELD_W | Epoch (marker) or offset (hit) |
| out_chan | output | IDX_W+CHAN_W | Global channel of a hit, 0 for a marker |

## Verification
A record taken at a clock edge through in_ready appears on out_valid right after that edge, since the output holds one register stage; a hit that opens a new epoch first costs one extra cycle for its inserted marker, and a duplicate marker is consumed in a cycle that yields no output. Because these delays vary, the bench does not wait a fixed number of cycles: it samples the handshakes mid-cycle, before the next rising edge, and compares each accepted output record against the next entry of a list computed up front by sorting the offered streams by (epoch, kind, offset, input, arrival). In-ready legality and the hold-under-stall rule are checked every cycle, and the first two cycles after reset release are checked for a quiet interface.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  // Action chosen by the merge decision in one cycle.
  typedef enum logic [2:0] {
    ACT_IDLE,    // nothing to do
    ACT_DROP,    // duplicate marker consumed, no output
    ACT_MARK,    // marker consumed and sent
    ACT_INSERT,  // marker inserted ahead of a hit, hit stays
    ACT_HIT      // hit consumed and sent
  } tsm_act_e;

  function automatic int unsigned wider(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tsm_rst_sync.sv
module tsm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/tsm_lane.sv
// Per-input epoch tracker and sort key builder.
module tsm_lane #(
  parameter int unsigned EPOCH_W = 8,
  parameter int unsigned OFFS_W  = 10,
  parameter int unsigned FIELD_W = 10,
  localparam int unsigned KEY_W  = EPOCH_W + 1 + OFFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rec_mark,
  input  logic [FIELD_W-1:0] rec_field,
  input  logic               take,
  output logic [KEY_W-1:0]   key
);
  logic [EPOCH_W-1:0] ep_q, ep_d;

  always_comb begin
    ep_d = ep_q;
    if (take && rec_mark) ep_d = rec_field[EPOCH_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ep_q <= '0;
    else        ep_q <= ep_d;
  end

  // Marker for E sorts ahead of every hit of E: kind bit 0 before 1.
  assign key = rec_mark ? {rec_field[EPOCH_W-1:0], 1'b0, {OFFS_W{1'b0}}}
                        : {ep_q, 1'b1, rec_field[OFFS_W-1:0]};
endmodule

// File: rtl/tsm_pick.sv
// Earliest-key selection; strict compare keeps the lowest index on ties.
module tsm_pick #(
  parameter int unsigned NUM_IN = 3,
  parameter int unsigned KEY_W  = 19,
  localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic [NUM_IN-1:0]       cand,
  input  logic [NUM_IN*KEY_W-1:0] keys,
  output logic                    any,
  output logic [IDX_W-1:0]        idx,
  output logic [KEY_W-1:0]        best
);
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (cand[i] && (!any || keys[i*KEY_W +: KEY_W] < best)) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        best = keys[i*KEY_W +: KEY_W];
      end
    end
  end
endmodule

// File: rtl/tsm_merge.sv
module tsm_merge
  import tsm_pkg::*;
#(
  parameter int unsigned NUM_IN  = 3,
  parameter int unsigned EPOCH_W = 8,
  parameter int unsigned OFFS_W  = 10,
  parameter int unsigned CHAN_W  = 6,
  localparam int unsigned IDX_W   = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int unsigned FIELD_W = wider(EPOCH_W, OFFS_W),
  localparam int unsigned KEY_W   = EPOCH_W + 1 + OFFS_W,
  localparam int unsigned GCH_W   = IDX_W + CHAN_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IN-1:0]         in_valid,
  output logic [NUM_IN-1:0]         in_ready,
  input  logic [NUM_IN-1:0]         in_mark,
  input  logic [NUM_IN*FIELD_W-1:0] in_field,
  input  logic [NUM_IN*CHAN_W-1:0]  in_chan,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic                      out_mark,
  output logic [FIELD_W-1:0]        out_field,
  output logic [GCH_W-1:0]          out_chan
);
  logic srst_n;
  tsm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  // Per-input lanes
  logic [NUM_IN*KEY_W-1:0] keys;
  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    tsm_lane #(.EPOCH_W(EPOCH_W), .OFFS_W(OFFS_W), .FIELD_W(FIELD_W)) u_lane (
      .clk      (clk),
      .rst_n    (srst_n),
      .rec_mark (in_mark[g]),
      .rec_field(in_field[g*FIELD_W +: FIELD_W]),
      .take     (in_ready[g]),
      .key      (keys[g*KEY_W +: KEY_W])
    );
  end

  logic             any;
  logic [IDX_W-1:0] win;
  logic [KEY_W-1:0] win_key;
  tsm_pick #(.NUM_IN(NUM_IN), .KEY_W(KEY_W)) u_pick (
    .cand(in_valid), .keys(keys), .any(any), .idx(win), .best(win_key)
  );

  logic [EPOCH_W-1:0] win_ep;
  logic [OFFS_W-1:0]  win_off;
  logic               win_is_hit;
  logic [CHAN_W-1:0]  win_chan;
  assign win_ep     = win_key[KEY_W-1 -: EPOCH_W];
  assign win_is_hit = win_key[OFFS_W];
  assign win_off    = win_key[OFFS_W-1:0];
  assign win_chan   = in_chan[win*CHAN_W +: CHAN_W];

  // State: output register and last epoch sent
  logic               ov_q, ov_d, om_q, om_d;
  logic [FIELD_W-1:0] of_q, of_d;
  logic [GCH_W-1:0]   oc_q, oc_d;
  logic [EPOCH_W-1:0] ep_q, ep_d;
  logic               seen_q, seen_d;
  logic               can_issue, take;
  tsm_act_e           act;

  assign can_issue = srst_n && (!ov_q || out_ready);

  always_comb begin
    act = ACT_IDLE;
    if (can_issue && any) begin
      if (!win_is_hit) act = (!seen_q || win_ep > ep_q) ? ACT_MARK : ACT_DROP;
      else             act = (!seen_q || win_ep != ep_q) ? ACT_INSERT : ACT_HIT;
    end
    take = (act == ACT_DROP) || (act == ACT_MARK) || (act == ACT_HIT);
  end

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) in_ready[i] = take && (win == IDX_W'(i));
  end

  always_comb begin
    ov_d   = ov_q && !out_ready;
    om_d   = om_q;
    of_d   = of_q;
    oc_d   = oc_q;
    ep_d   = ep_q;
    seen_d = seen_q;
    unique case (act)
      ACT_MARK, ACT_INSERT: begin
        ov_d   = 1'b1;
        om_d   = 1'b1;
        of_d   = FIELD_W'(win_ep);
        oc_d   = '0;
        ep_d   = win_ep;
        seen_d = 1'b1;
      end
      ACT_HIT: begin
        ov_d = 1'b1;
        om_d = 1'b0;
        of_d = FIELD_W'(win_off);
        oc_d = {win, win_chan};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ov_q   <= 1'b0;
      om_q   <= 1'b0;
      of_q   <= '0;
      oc_q   <= '0;
      ep_q   <= '0;
      seen_q <= 1'b0;
    end else begin
      ov_q   <= ov_d;
      om_q   <= om_d;
      of_q   <= of_d;
      oc_q   <= oc_d;
      ep_q   <= ep_d;
      seen_q <= seen_d;
    end
  end

  assign out_valid = ov_q;
  assign out_mark  = om_q;
  assign out_field = of_q;
  assign out_chan  = oc_q;
endmodule

// File: rtl/tsm_merge_chk.sv
module tsm_merge_chk
  import tsm_pkg::*;
#(
  parameter int unsigned NUM_IN  = 3,
  parameter int unsigned EPOCH_W = 8,
  parameter int unsigned OFFS_W  = 10,
  parameter int unsigned CHAN_W  = 6,
  localparam int unsigned IDX_W   = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int unsigned FIELD_W = wider(EPOCH_W, OFFS_W),
  localparam int unsigned GCH_W   = IDX_W + CHAN_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IN-1:0]  in_valid,
  input logic [NUM_IN-1:0]  in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_mark,
  input logic [FIELD_W-1:0] out_field,
  input logic [GCH_W-1:0]   out_chan
);
  logic               mk_seen, hit_seen;
  logic [EPOCH_W-1:0] last_ep;
  logic [FIELD_W-1:0] last_off;
  logic               fire;
  assign fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk_seen  <= 1'b0;
      hit_seen <= 1'b0;
      last_ep  <= '0;
      last_off <= '0;
    end else if (fire) begin
      if (out_mark) begin
        mk_seen  <= 1'b1;
        hit_seen <= 1'b0;
        last_ep  <= out_field[EPOCH_W-1:0];
      end else begin
        hit_seen <= 1'b1;
        last_off <= out_field;
      end
    end
  end

  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));
  assert_grant_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mark) && $stable(out_field) && $stable(out_chan));
  assert_marker_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_mark && mk_seen |-> out_field[EPOCH_W-1:0] > last_ep);
  assert_hit_after_marker_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_mark |-> mk_seen);
  assert_hit_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !out_mark && hit_seen |-> out_field >= last_off);
  assert_marker_chan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mark |-> out_chan == '0);
endmodule

bind tsm_merge tsm_merge_chk #(
  .NUM_IN(NUM_IN), .EPOCH_W(EPOCH_W), .OFFS_W(OFFS_W), .CHAN_W(CHAN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_mark(out_mark),
  .out_field(out_field), .out_chan(out_chan)
);

// File: tb/tsm_merge_bench.sv
`timescale 1ns/1ps
module tsm_merge_bench;
  localparam int NIN = 3;
  localparam int FW  = 10;
  localparam int CW  = 6;
  localparam int GW  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NIN-1:0]    in_valid, in_ready, in_mark;
  logic [NIN*FW-1:0] in_field;
  logic [NIN*CW-1:0] in_chan;
  logic              out_valid, out_ready, out_mark;
  logic [FW-1:0]     out_field;
  logic [GW-1:0]     out_chan;

  always #4 clk = ~clk;

  tsm_merge u_tsm_merge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mark(in_mark), .in_field(in_field), .in_chan(in_chan),
    .out_valid(out_valid), .out_ready(out_ready), .out_mark(out_mark),
    .out_field(out_field), .out_chan(out_chan)
  );

  typedef struct packed { logic m; logic [15:0] f; logic [7:0] c; } rec_t;
  typedef struct { longint k; logic m; int f; int c; } ent_t;

  rec_t qs[NIN][$];
  ent_t expq[$];
  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  bit   done   = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R9 watchdog expired: actual cycle %0d expected < 150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_m(input int p, input int ep);
    rec_t r; r.m = 1'b1; r.f = 16'(ep); r.c = 8'd0; qs[p].push_back(r);
  endtask
  task automatic push_h(input int p, input int off, input int ch);
    rec_t r; r.m = 1'b0; r.f = 16'(off); r.c = 8'(ch); qs[p].push_back(r);
  endtask

  task automatic add_ent(input ent_t e);
    int pos = expq.size();
    for (int i = 0; i < expq.size(); i++) if (e.k < expq[i].k) begin pos = i; break; end
    expq.insert(pos, e);
  endtask

  // Expected output: every epoch once, then its hits by (offset, input, arrival).
  task automatic build_expected();
    bit eps[int];
    ent_t e;
    expq.delete();
    for (int p = 0; p < NIN; p++) begin
      int cur = 0;
      for (int s = 0; s < qs[p].size(); s++) begin
        if (qs[p][s].m) begin
          cur = int'(qs[p][s].f); eps[cur] = 1'b1;
        end else begin
          eps[cur] = 1'b1;
          e.k = ((((longint'(cur) * 2 + 1) * 1024 + longint'(qs[p][s].f)) * 4 + p) * 256) + s;
          e.m = 1'b0; e.f = int'(qs[p][s].f); e.c = p * 64 + int'(qs[p][s].c);
          add_ent(e);
        end
      end
    end
    foreach (eps[ep]) begin
      e.k = longint'(ep) * 2 * 1024 * 4 * 256;
      e.m = 1'b1; e.f = ep; e.c = 0;
      add_ent(e);
    end
  endtask

  task automatic drive();
    for (int p = 0; p < NIN; p++) begin
      if (qs[p].size() > 0) begin
        in_valid[p] = 1'b1;
        in_mark[p]  = qs[p][0].m;
        in_field[p*FW +: FW] = qs[p][0].f[FW-1:0];
        in_chan[p*CW +: CW]  = qs[p][0].c[CW-1:0];
      end else begin
        in_valid[p] = 1'b0; in_mark[p] = 1'b0;
        in_field[p*FW +: FW] = '0; in_chan[p*CW +: CW] = '0;
      end
    end
  endtask

  task automatic run(input string req, input int mode);
    int   guard = 0;
    bit   stall = 0;
    logic sm; logic [FW-1:0] sf; logic [GW-1:0] sc;
    logic [NIN-1:0] took;
    build_expected();
    while ((qs[0].size() + qs[1].size() + qs[2].size() + expq.size()) > 0 && guard < 3000) begin
      guard++;
      @(negedge clk);
      drive();
      out_ready = (mode == 0) ? 1'b1 : (((guard * 7 + 3) % 5) >= 2);
      #2;
      check(((in_ready & ~in_valid) == '0) && ($countones(in_ready) <= 1), "R10",
            "in_ready legality", int'(in_ready), int'(in_valid));
      if (stall)
        check(out_valid && out_mark == sm && out_field == sf && out_chan == sc, "R9",
              "held record", int'(out_field), int'(sf));
      stall = out_valid && !out_ready;
      sm = out_mark; sf = out_field; sc = out_chan;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check(1'b0, req, "unexpected record", int'(out_field), -1);
        else begin
          ent_t e = expq.pop_front();
          check(out_mark == e.m, req, "record kind", int'(out_mark), int'(e.m));
          check(int'(out_field) == e.f, req, "time field", int'(out_field), e.f);
          check(int'(out_chan) == e.c, (e.m ? "R7" : req), "channel", int'(out_chan), e.c);
        end
      end
      took = in_ready & in_valid;
      @(posedge clk);
      for (int p = 0; p < NIN; p++) if (took[p]) void'(qs[p].pop_front());
    end
    check(expq.size() == 0, req, "records left undelivered", expq.size(), 0);
    @(negedge clk);
    drive();
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #2;
      check(!out_valid, "R3", "extra output after drain", int'(out_valid), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; out_ready = 1'b1;
    in_valid = '0; in_mark = '0; in_field = '0; in_chan = '0;
    repeat (3) @(negedge clk);
    // R1: offer a record during reset
    in_valid = 3'b001; in_mark = 3'b000; in_field[FW-1:0] = 10'd5;
    #2;
    check(in_ready == '0, "R1", "in_ready in reset", int'(in_ready), 0);
    check(!out_valid, "R1", "out_valid in reset", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(in_ready == '0, "R1", "in_ready before sync release", int'(in_ready), 0);
    check(!out_valid, "R1", "out_valid before sync release", int'(out_valid), 0);
    @(negedge clk);
    in_valid = '0;
    repeat (3) @(negedge clk);
    check(!out_valid, "R1", "out_valid idle after reset", int'(out_valid), 0);

    // R2/R3: interleaved streams with duplicate markers
    push_m(0, 1); push_h(0, 10, 1); push_h(0, 40, 2); push_m(0, 2); push_h(0, 5, 3);
    push_m(1, 1); push_h(1, 20, 4); push_h(1, 30, 5); push_m(1, 2); push_h(1, 1, 6);
    run("R2", 0);

    // R6: equal timestamps on all inputs
    push_m(0, 3); push_h(0, 7, 1); push_h(0, 9, 2);
    push_m(1, 3); push_h(1, 7, 3); push_h(1, 9, 4);
    push_m(2, 3); push_h(2, 7, 5); push_h(2, 7, 6);
    run("R6", 0);

    // R5: epochs without hits still get one marker
    push_m(0, 4); push_m(0, 5); push_m(0, 6); push_h(0, 5, 7);
    push_m(1, 4); push_m(1, 6); push_h(1, 2, 8);
    push_m(2, 7);
    run("R5", 0);

    // R8: one input far ahead holds its marker back
    push_m(0, 12); push_h(0, 3, 1);
    push_m(1, 8); push_h(1, 100, 2); push_h(1, 900, 3); push_m(1, 12); push_h(1, 3, 4);
    push_m(2, 9); push_h(2, 50, 5);
    run("R8", 0);

    // R9: mixed traffic under back-pressure
    push_m(0, 20); push_h(0, 1, 10); push_h(0, 4, 11); push_h(0, 8, 12); push_m(0, 21); push_h(0, 2, 13);
    push_m(1, 20); push_h(1, 3, 20); push_m(1, 21); push_h(1, 2, 21); push_h(1, 6, 22);
    push_m(2, 21); push_h(2, 0, 30); push_m(2, 22);
    run("R9", 1);

    // R4: hits before any marker on a fresh reset
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    push_h(0, 7, 1); push_m(0, 1); push_h(0, 3, 2);
    push_h(1, 2, 3); push_h(1, 7, 4);
    run("R4", 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule